// File: doc/BRIEF.md
# Strobe-Latched Memory Read Port

This block is a cycle-based model of a small non-volatile memory with a strobed read interface. A read begins when the active-low strobe `strb_n` falls. On that clock edge the address is captured and, in the byte-wide organization, so is an auxiliary enable. Changes on the address and enable pins after that edge have no effect on the cycle. After the capture there is one internal cycle in which the bus stays in high impedance. The bus is then driven with data marked as not yet valid, and it carries valid data once a parameterised access delay has run out. The data bus is driven only while three conditions hold together: the strobe is low, the level-sensitive select `sel_n` is low, and the captured enable is active. Raising either the strobe or the select releases the bus in the same cycle.

Two organizations are chosen by parameter: 512 words of 8 bits with the captured enable, or 1024 words of 4 bits without it. The array is made of registers. Reset puts it in the erased state, with every bit at one. A programming port can only clear bits, never set them. Between cycles the strobe must stay high for a minimum number of clock cycles. A fall that comes too early is ignored and flagged.

The controller has four states. IDLE waits for an accepted fall and moves to LATCH. LATCH returns to IDLE if the strobe is high, and otherwise moves to ACCESS. ACCESS returns to IDLE if the strobe is high, and otherwise moves to VALID when the delay completes. VALID returns to IDLE when the strobe is high.

Top module: `strobe_rom_port`

## Requirements
- R1: After reset every word reads as all ones. The bus is not driven, and `q_oe`, `q_stale`, `q_valid` and `proto_err` are all 0.
- R2: A programming write with `prog_we`=1 updates the word at `prog_addr` to its old value AND `prog_data`, so it can only clear bits.
- R3: The address and the auxiliary enable are sampled on the clock edge where the strobe is first seen low. Later changes on those pins do not alter the word read in that cycle.
- R4: In the clock cycle after the capturing edge (state LATCH), `q_oe`=0, `q_stale`=0 and `q_valid`=0.
- R5: From the second cycle after capture until ACCESS_CYC edges after capture, the bus is driven with `q_oe`=1 and `q_stale`=1 (state ACCESS).
- R6: From ACCESS_CYC edges after capture, `q_valid`=1 and the bus carries the word at the captured address. It stays so while the strobe and the select remain low.
- R7: The select is level-sensitive and is not latched. While `sel_n`=1, `q_oe`, `q_stale` and `q_valid` are 0. Lowering `sel_n` again in the same cycle restores the drive.
- R8: Raising the strobe clears `q_oe` and `q_valid` at once and ends the cycle. A new cycle needs a fresh fall.
- R9: In the byte-wide organization, if the captured enable `aux_en` is 0 then `q_oe` stays 0 for the whole cycle.
- R10: A fall that comes after fewer than MIN_HIGH_CYC clock edges with the strobe high is ignored: the bus stays undriven. The fall raises `proto_err` for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; erases the array |
| strb_n | input | 1 | Active-low strobe; its fall captures address and enable |
| sel_n | input | 1 | Active-low level-sensitive output select |
| aux_en | input | 1 | Auxiliary enable captured with the address (byte-wide organization only) |
| addr | input | AW | Read address (9 or 10 bits) |
| prog_we | input | 1 | Programming write strobe |
| prog_addr | input | AW | Programming address |
| prog_data | input | DW | Programming data; zero bits clear stored bits |
| q_bus | output | DW | Three-state data bus (8 or 4 bits) |
| q_oe | output | 1 | High while the bus is driven |
| q_stale | output | 1 | Bus driven, data not yet valid |
| q_valid | output | 1 | Bus driven with valid data |
| proto_err | output | 1 | One-cycle pulse on an ignored premature strobe fall |

## Verification
The bench programs all 512 words with an arithmetic pattern and then reprograms some of them, so it can tell an AND update from a plain overwrite. It reads every word and walks through the undriven, stale and valid phases. While a cycle is running it moves the address pins; a design that tracks the pins instead of the captured value would return the wrong word. It pulls the select high and low again during the valid phase, which a design that latched the select would miss. It also runs a cycle with the enable low, and one whose fall comes too early; a design that did not enforce the minimum high time would drive the bus without raising `proto_err`.

// File: rtl/srp_pkg.sv
package srp_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LATCH  = 2'd1,
        ST_ACCESS = 2'd2,
        ST_VALID  = 2'd3
    } srp_state_e;
endpackage

// File: rtl/srp_cell_array.sv
module srp_cell_array #(
    parameter int AW = 9,
    parameter int DW = 8,
    localparam int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          prog_we,
    input  logic [AW-1:0] prog_addr,
    input  logic [DW-1:0] prog_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) cells[i] <= '1;
        end else if (prog_we) begin
            cells[prog_addr] <= cells[prog_addr] & prog_data;
        end
    end

    assign rd_data = cells[rd_addr];

    // programming may only clear bits
    assert_clear_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
        prog_we |=> ((cells[$past(prog_addr)] & ~$past(prog_data)) == '0));
endmodule

// File: rtl/srp_strobe_fsm.sv
module srp_strobe_fsm
    import srp_pkg::*;
#(
    parameter int WIDE_ORG     = 1,
    parameter int AW           = 9,
    parameter int ACCESS_CYC   = 3,
    parameter int MIN_HIGH_CYC = 2,
    localparam int ACW = $clog2(ACCESS_CYC + 1),
    localparam int HCW = $clog2(MIN_HIGH_CYC + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          strb_n,
    input  logic          aux_en,
    input  logic [AW-1:0] addr,
    output srp_state_e    st,
    output logic [AW-1:0] lat_addr,
    output logic          lat_en,
    output logic          proto_err
);
    srp_state_e     st_nx;
    logic           strb_q;
    logic [ACW-1:0] acc_cnt;
    logic [HCW-1:0] hi_cnt;
    logic           fall;
    logic           ready;
    logic           accept;

    assign fall   = strb_q && !strb_n;
    assign ready  = (hi_cnt >= HCW'(MIN_HIGH_CYC));
    assign accept = (st == ST_IDLE) && fall && ready;

    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE:   if (accept) st_nx = ST_LATCH;
            ST_LATCH:  st_nx = strb_n ? ST_IDLE : ST_ACCESS;
            ST_ACCESS: begin
                if (strb_n)                                st_nx = ST_IDLE;
                else if (acc_cnt == ACW'(ACCESS_CYC - 1)) st_nx = ST_VALID;
            end
            ST_VALID:  if (strb_n) st_nx = ST_IDLE;
            default:   st_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            strb_q    <= 1'b1;
            acc_cnt   <= '0;
            hi_cnt    <= HCW'(MIN_HIGH_CYC);
            lat_addr  <= '0;
            proto_err <= 1'b0;
        end else begin
            strb_q    <= strb_n;
            proto_err <= (st == ST_IDLE) && fall && !ready;
            if (accept) lat_addr <= addr;
            if (st == ST_LATCH)       acc_cnt <= ACW'(1);
            else if (st == ST_ACCESS) acc_cnt <= acc_cnt + ACW'(1);
            if (!strb_n)     hi_cnt <= '0;
            else if (!ready) hi_cnt <= hi_cnt + HCW'(1);
        end
    end

    generate
        if (WIDE_ORG != 0) begin : g_en_latch
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)      lat_en <= 1'b0;
                else if (accept) lat_en <= aux_en;
            end
        end else begin : g_no_en
            logic unused_aux;
            assign unused_aux = aux_en;
            assign lat_en     = 1'b1;
        end
    endgenerate

    assert_latch_from_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_LATCH) |-> ($past(st) == ST_IDLE));
    assert_valid_after_access_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_VALID && $past(st) != ST_VALID) |-> ($past(st) == ST_ACCESS));
    assert_err_keeps_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |-> (st == ST_IDLE));
endmodule

// File: rtl/srp_out_stage.sv
module srp_out_stage
    import srp_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  srp_state_e    st,
    input  logic          strb_n,
    input  logic          sel_n,
    input  logic          lat_en,
    input  logic [DW-1:0] rd_data,
    output logic [DW-1:0] q_bus,
    output logic          q_oe,
    output logic          q_stale,
    output logic          q_valid
);
    logic phase_on;

    always_comb begin
        unique case (st)
            ST_ACCESS, ST_VALID: phase_on = 1'b1;
            default:             phase_on = 1'b0;
        endcase
    end

    assign q_oe    = phase_on && lat_en && !sel_n && !strb_n;
    assign q_stale = q_oe && (st == ST_ACCESS);
    assign q_valid = q_oe && (st == ST_VALID);
    assign q_bus   = q_oe ? rd_data : 'z;

    // valid data is only ever reached through the access phase
    assert_valid_needs_access_R6: assert property (@(posedge clk) disable iff (!rst_n)
        q_valid |-> ($past(st) != ST_IDLE));
endmodule

// File: rtl/strobe_rom_port.sv
module strobe_rom_port
    import srp_pkg::*;
#(
    parameter int WIDE_ORG     = 1,
    parameter int ACCESS_CYC   = 3,
    parameter int MIN_HIGH_CYC = 2,
    localparam int DW = (WIDE_ORG != 0) ? 8 : 4,
    localparam int AW = (WIDE_ORG != 0) ? 9 : 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          strb_n,
    input  logic          sel_n,
    input  logic          aux_en,
    input  logic [AW-1:0] addr,
    input  logic          prog_we,
    input  logic [AW-1:0] prog_addr,
    input  logic [DW-1:0] prog_data,
    output logic [DW-1:0] q_bus,
    output logic          q_oe,
    output logic          q_stale,
    output logic          q_valid,
    output logic          proto_err
);
    srp_state_e    st;
    logic [AW-1:0] lat_addr;
    logic          lat_en;
    logic [DW-1:0] rd_data;

    srp_strobe_fsm #(
        .WIDE_ORG(WIDE_ORG), .AW(AW),
        .ACCESS_CYC(ACCESS_CYC), .MIN_HIGH_CYC(MIN_HIGH_CYC)
    ) fsm_i (
        .clk(clk), .rst_n(rst_n), .strb_n(strb_n), .aux_en(aux_en),
        .addr(addr), .st(st), .lat_addr(lat_addr), .lat_en(lat_en),
        .proto_err(proto_err)
    );

    srp_cell_array #(.AW(AW), .DW(DW)) array_i (
        .clk(clk), .rst_n(rst_n), .prog_we(prog_we), .prog_addr(prog_addr),
        .prog_data(prog_data), .rd_addr(lat_addr), .rd_data(rd_data)
    );

    srp_out_stage #(.DW(DW)) out_i (
        .clk(clk), .rst_n(rst_n), .st(st), .strb_n(strb_n), .sel_n(sel_n),
        .lat_en(lat_en), .rd_data(rd_data), .q_bus(q_bus), .q_oe(q_oe),
        .q_stale(q_stale), .q_valid(q_valid)
    );

    assert_no_drive_on_strobe_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (strb_n && $past(strb_n)) |-> !q_oe);
endmodule

// File: tb/strobe_rom_port_tb_top.sv
module strobe_rom_port_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       strb_n = 1'b1;
    logic       sel_n = 1'b1;
    logic       aux_en = 1'b0;
    logic [8:0] addr = '0;
    logic       prog_we = 1'b0;
    logic [8:0] prog_addr = '0;
    logic [7:0] prog_data = '0;
    wire  [7:0] q_bus;
    wire        q_oe, q_stale, q_valid, proto_err;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    strobe_rom_port dut_i (
        .clk(clk), .rst_n(rst_n), .strb_n(strb_n), .sel_n(sel_n),
        .aux_en(aux_en), .addr(addr), .prog_we(prog_we),
        .prog_addr(prog_addr), .prog_data(prog_data), .q_bus(q_bus),
        .q_oe(q_oe), .q_stale(q_stale), .q_valid(q_valid),
        .proto_err(proto_err)
    );

    function automatic logic [7:0] pat(int a);
        return 8'((a * 37 + 5) & 255);
    endfunction

    function automatic logic [7:0] expect_word(int a);
        return (a % 16 == 0) ? (pat(a) & 8'h0F) : pat(a);
    endfunction

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic flags(string req, logic oe, logic st, logic vl);
        chk(req, {5'd0, q_oe, q_stale, q_valid}, {5'd0, oe, st, vl});
    endtask

    // full read cycle; ACCESS_CYC = 3, MIN_HIGH_CYC = 2
    task automatic rd(int a, logic en, logic [7:0] exp);
        strb_n = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        addr = 9'(a); aux_en = en; strb_n = 1'b0; sel_n = 1'b0;
        @(negedge clk); #1;
        flags("R4 latch phase", 1'b0, 1'b0, 1'b0);
        addr = ~9'(a); aux_en = ~en;            // R3 pins move after capture
        @(negedge clk); #1;
        if (en) begin
            flags("R5 stale phase", 1'b1, 1'b1, 1'b0);
        end else begin
            flags("R9 disabled cycle", 1'b0, 1'b0, 1'b0);
        end
        @(negedge clk); #1;
        if (en) flags("R5 stale phase end", 1'b1, 1'b1, 1'b0);
        else    flags("R9 disabled cycle", 1'b0, 1'b0, 1'b0);
        @(negedge clk); #1;
        if (en) begin
            flags("R6 valid phase", 1'b1, 1'b0, 1'b1);
            chk("R6 R3 data", q_bus, exp);
        end else begin
            flags("R9 disabled cycle", 1'b0, 1'b0, 1'b0);
        end
        strb_n = 1'b1; #1;
        flags("R8 strobe release", 1'b0, 1'b0, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        flags("R1 reset outputs", 1'b0, 1'b0, 1'b0);
        chk("R1 reset error flag", {7'd0, proto_err}, 8'd0);
        rd(5, 1'b1, 8'hFF);
        rd(511, 1'b1, 8'hFF);

        // program every word, then clear more bits in some (R2)
        @(negedge clk);
        for (int a = 0; a < 512; a++) begin
            prog_we = 1'b1; prog_addr = 9'(a); prog_data = pat(a);
            @(negedge clk);
        end
        for (int a = 0; a < 512; a += 16) begin
            prog_we = 1'b1; prog_addr = 9'(a); prog_data = 8'h0F;
            @(negedge clk);
        end
        prog_we = 1'b0;

        for (int a = 0; a < 512; a++) rd(a, 1'b1, expect_word(a));  // R2 R6

        rd(77, 1'b0, 8'h00);                      // R9

        // select toggled mid-cycle (R7)
        rd(33, 1'b1, expect_word(33));
        strb_n = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        addr = 9'd200; aux_en = 1'b1; strb_n = 1'b0; sel_n = 1'b0;
        repeat (4) @(negedge clk);
        #1; flags("R7 before toggle", 1'b1, 1'b0, 1'b1);
        sel_n = 1'b1; #1;
        flags("R7 select high", 1'b0, 1'b0, 1'b0);
        @(negedge clk); #1;
        flags("R7 select still high", 1'b0, 1'b0, 1'b0);
        sel_n = 1'b0; #1;
        flags("R7 select low again", 1'b1, 1'b0, 1'b1);
        chk("R7 data after toggle", q_bus, expect_word(200));
        strb_n = 1'b1;

        // premature fall after a single high edge (R10)
        @(posedge clk);
        @(negedge clk);
        addr = 9'd9; aux_en = 1'b1; strb_n = 1'b0;
        @(negedge clk); #1;
        chk("R10 error pulse", {7'd0, proto_err}, 8'd1);
        flags("R10 ignored fall", 1'b0, 1'b0, 1'b0);
        @(negedge clk); #1;
        chk("R10 pulse one cycle", {7'd0, proto_err}, 8'd0);
        repeat (4) @(negedge clk);
        #1; flags("R10 stays idle", 1'b0, 1'b0, 1'b0);
        rd(9, 1'b1, expect_word(9));

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule